// File: doc/BRIEF.md
# Coherent Cache Line-Lock Controller

This block sits on the cache side of a directory-based MESI protocol. It stops messages that the network delivers out of order from corrupting a line's coherence state. A write hit or an eviction on a coherent line does two things: it places the line into a small lock table and sends a notice to the directory. The line stays locked until the directory acknowledges that notice. The acknowledgement then commits the pending state change and frees the table slot. Because the line stays locked in between, a later miss on the same line cannot race ahead of the eviction notice.

The replacement logic asks the controller whether a candidate line is locked, and a locked line is never evicted. Requests on non-coherent lines pass straight through, with no lock and no notice. Coherence can be turned on at any cache level, so the coherent flag comes in with each request.

Top module: `line_lock_ctrl`

## Requirements
- R1: A coherent write hit is accepted when `wh_ready` is high and `wh_valid` is high. One cycle later a notice appears on the directory port with `dir_msg_evict`=0 and the request address, and the line reads as locked on the probe port.
- R2: A coherent eviction is accepted when `ev_ready` is high and `ev_valid` is high. One cycle later a notice appears with `dir_msg_evict`=1 and the eviction address, and the line reads as locked.
- R3: `probe_locked` is 1 exactly when the probed address is held in the lock table. A coherent eviction of a locked line is refused (`ev_ready`=0).
- R4: An acknowledgement whose address matches a locked line raises `commit_valid` one cycle later, carrying that address. `commit_state` uses the encoding I=0, S=1, E=2, M=3. A write-hit lock commits M (3) and an eviction lock commits I (0). The lock is released at the same edge.
- R5: When all `SLOTS` entries are in use, coherent write hits and coherent evictions are refused until an entry is freed.
- R6: A coherent write hit to a locked line is refused until that line's acknowledgement has been taken. The request is accepted in the first cycle after the release.
- R7: An acknowledgement that matches no locked line changes no lock and produces no commit. It raises `ack_orphan` for one cycle, one cycle later.
- R8: Requests with the coherent flag low are always ready. They send no notice and lock nothing.
- R9: When a coherent eviction and a coherent write hit arrive in the same cycle, the eviction takes the cycle and the write hit is refused for that cycle.
- R10: After reset the table is empty, every output flag is low, and both request ports are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wh_valid | input | 1 | Write-hit request present |
| wh_coherent | input | 1 | Write-hit line is kept coherent |
| wh_addr | input | ADDR_W | Write-hit line address |
| wh_ready | output | 1 | Write-hit request accepted this cycle if valid |
| ev_valid | input | 1 | Eviction request present |
| ev_coherent | input | 1 | Evicted line is kept coherent |
| ev_addr | input | ADDR_W | Evicted line address |
| ev_ready | output | 1 | Eviction accepted this cycle if valid |
| dir_msg_valid | output | 1 | Notice to the directory is present |
| dir_msg_evict | output | 1 | Notice kind: 0 write hit, 1 eviction |
| dir_msg_addr | output | ADDR_W | Line address of the notice |
| ack_valid | input | 1 | Directory acknowledgement present |
| ack_addr | input | ADDR_W | Acknowledged line address |
| commit_valid | output | 1 | A pending state change is committed |
| commit_addr | output | ADDR_W | Line whose state is committed |
| commit_state | output | 2 | Committed MESI state (I=0,S=1,E=2,M=3) |
| ack_orphan | output | 1 | Acknowledgement matched no locked line |
| probe_addr | input | ADDR_W | Replacement candidate address |
| probe_locked | output | 1 | Candidate is locked and must not be evicted |

## Verification
The hardest situation to reach is a refused request that waits on its own line while the directory answers in the same cycle. The bench holds a write hit on a locked line and raises the matching acknowledgement while the request is still held. It then checks that the request stays refused in that cycle and is taken in the next one. The table-full stall is reached by filling every slot with a mix of write and eviction locks. The same-cycle contest between both request ports is staged while one slot is still free, so the priority shows up on the ready flags and in the notice kind.

// File: rtl/llc_pkg.sv
package llc_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_e;

    typedef enum logic {
        PEND_WRITE = 1'b0,
        PEND_EVICT = 1'b1
    } pend_e;

    // State a line settles into once its lock is acknowledged
    function automatic mesi_e settle_state(pend_e p);
        return (p == PEND_WRITE) ? MESI_M : MESI_I;
    endfunction

endpackage

// File: rtl/lock_free_pick.sv
module lock_free_pick #(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0] busy,
    output logic [SLOTS-1:0] grant,
    output logic             none_free
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
        none_free = !found;
    end
endmodule

// File: rtl/lock_slot.sv
module lock_slot
    import llc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic              release_i,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  pend_e             alloc_act,
    input  logic [ADDR_W-1:0] cmp_wr,
    input  logic [ADDR_W-1:0] cmp_ev,
    input  logic [ADDR_W-1:0] cmp_ack,
    input  logic [ADDR_W-1:0] cmp_q,
    output logic              busy,
    output pend_e             act,
    output logic              hit_wr,
    output logic              hit_ev,
    output logic              hit_ack,
    output logic              hit_q
);
    logic [ADDR_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            line_q <= '0;
            act    <= PEND_WRITE;
        end else if (alloc) begin
            busy   <= 1'b1;
            line_q <= alloc_addr;
            act    <= alloc_act;
        end else if (release_i) begin
            busy   <= 1'b0;
        end
    end

    assign hit_wr  = busy && (line_q == cmp_wr);
    assign hit_ev  = busy && (line_q == cmp_ev);
    assign hit_ack = busy && (line_q == cmp_ack);
    assign hit_q   = busy && (line_q == cmp_q);

    // R5: a slot is only ever filled while it is empty
    p_alloc_free_r5: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !busy);

    // R4: a release leaves the slot empty at the next edge
    p_release_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (release_i && !alloc) |=> !busy);
endmodule

// File: rtl/line_lock_ctrl.sv
module line_lock_ctrl
    import llc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wh_valid,
    input  logic              wh_coherent,
    input  logic [ADDR_W-1:0] wh_addr,
    output logic              wh_ready,
    input  logic              ev_valid,
    input  logic              ev_coherent,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic              ev_ready,
    output logic              dir_msg_valid,
    output logic              dir_msg_evict,
    output logic [ADDR_W-1:0] dir_msg_addr,
    input  logic              ack_valid,
    input  logic [ADDR_W-1:0] ack_addr,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [1:0]        commit_state,
    output logic              ack_orphan,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_locked
);
    localparam int LAST = SLOTS - 1;

    logic [LAST:0] busy, grant, hit_wr, hit_ev, hit_ack, hit_q;
    pend_e         slot_act [SLOTS];
    logic          table_full;
    logic          ev_take, wh_take, do_alloc;
    logic [ADDR_W-1:0] alloc_addr;
    pend_e         alloc_act, ack_act;

    lock_free_pick #(.SLOTS(SLOTS)) u_pick (
        .busy      (busy),
        .grant     (grant),
        .none_free (table_full)
    );

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            lock_slot #(.ADDR_W(ADDR_W)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .alloc      (do_alloc && grant[g]),
                .release_i  (ack_valid && hit_ack[g]),
                .alloc_addr (alloc_addr),
                .alloc_act  (alloc_act),
                .cmp_wr     (wh_addr),
                .cmp_ev     (ev_addr),
                .cmp_ack    (ack_addr),
                .cmp_q      (probe_addr),
                .busy       (busy[g]),
                .act        (slot_act[g]),
                .hit_wr     (hit_wr[g]),
                .hit_ev     (hit_ev[g]),
                .hit_ack    (hit_ack[g]),
                .hit_q      (hit_q[g])
            );
        end
    endgenerate

    // Eviction has priority; a locked line is never evicted again
    always_comb begin
        logic ev_ok;
        ev_ok    = !table_full && !(|hit_ev);
        ev_ready = !ev_coherent || ev_ok;
        ev_take  = ev_valid && ev_coherent && ev_ok;
        wh_ready = !wh_coherent || (!table_full && !(|hit_wr) && !ev_take);
        wh_take  = wh_valid && wh_coherent && wh_ready;
        do_alloc = ev_take || wh_take;
        alloc_addr = ev_take ? ev_addr : wh_addr;
        alloc_act  = ev_take ? PEND_EVICT : PEND_WRITE;
    end

    always_comb begin
        ack_act = PEND_WRITE;
        for (int i = 0; i < SLOTS; i++)
            if (hit_ack[i]) ack_act = slot_act[i];
    end

    assign probe_locked = |hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_msg_valid <= 1'b0;
            dir_msg_evict <= 1'b0;
            dir_msg_addr  <= '0;
            commit_valid  <= 1'b0;
            commit_addr   <= '0;
            commit_state  <= MESI_I;
            ack_orphan    <= 1'b0;
        end else begin
            dir_msg_valid <= do_alloc;
            dir_msg_evict <= ev_take;
            dir_msg_addr  <= alloc_addr;
            commit_valid  <= ack_valid && (|hit_ack);
            commit_addr   <= ack_addr;
            commit_state  <= settle_state(ack_act);
            ack_orphan    <= ack_valid && !(|hit_ack);
        end
    end

    p_wh_notice_r1: assert property (@(posedge clk) disable iff (rst)
        wh_take |=> dir_msg_valid && !dir_msg_evict && dir_msg_addr == $past(wh_addr));

    p_ev_notice_r2: assert property (@(posedge clk) disable iff (rst)
        ev_take |=> dir_msg_valid && dir_msg_evict && dir_msg_addr == $past(ev_addr));

    p_unique_lock_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_q));

    p_full_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (&busy) |-> !do_alloc);

    p_orphan_no_commit_r7: assert property (@(posedge clk) disable iff (rst)
        ack_orphan |-> !commit_valid);

    p_noncoh_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !ev_coherent) |-> ev_ready);

    p_evict_first_r9: assert property (@(posedge clk) disable iff (rst)
        ev_take |-> !wh_take);
endmodule

// File: tb/sim_line_lock_ctrl.sv
`timescale 1ns/1ps
module sim_line_lock_ctrl;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst;
    logic wh_valid, wh_coherent, ev_valid, ev_coherent, ack_valid;
    logic [AW-1:0] wh_addr, ev_addr, ack_addr, probe_addr;
    logic wh_ready, ev_ready, dir_msg_valid, dir_msg_evict;
    logic [AW-1:0] dir_msg_addr, commit_addr;
    logic commit_valid, ack_orphan, probe_locked;
    logic [1:0] commit_state;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    line_lock_ctrl #(.ADDR_W(AW), .SLOTS(4)) u0 (
        .clk(clk), .rst(rst),
        .wh_valid(wh_valid), .wh_coherent(wh_coherent), .wh_addr(wh_addr), .wh_ready(wh_ready),
        .ev_valid(ev_valid), .ev_coherent(ev_coherent), .ev_addr(ev_addr), .ev_ready(ev_ready),
        .dir_msg_valid(dir_msg_valid), .dir_msg_evict(dir_msg_evict), .dir_msg_addr(dir_msg_addr),
        .ack_valid(ack_valid), .ack_addr(ack_addr),
        .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_state(commit_state),
        .ack_orphan(ack_orphan), .probe_addr(probe_addr), .probe_locked(probe_locked)
    );

    // op: 0 write hit, 1 eviction, 2 ack, 3 probe
    // exp: request -> accepted; ack -> bit3 orphan, bits1:0 state; probe -> locked
    localparam logic [21:0] VEC [14] = '{
        {2'd0, 16'h0010, 4'd1},  // R1 write hit locks
        {2'd3, 16'h0010, 4'd1},  // R3 locked
        {2'd0, 16'h0010, 4'd0},  // R6 write hit on locked line refused
        {2'd1, 16'h0010, 4'd0},  // R3 locked line not evicted
        {2'd1, 16'h0020, 4'd1},  // R2 eviction locks
        {2'd2, 16'h0010, 4'd3},  // R4 write lock commits M
        {2'd3, 16'h0010, 4'd0},  // R4 released
        {2'd2, 16'h0020, 4'd0},  // R4 evict lock commits I
        {2'd2, 16'h0030, 4'd8},  // R7 orphan ack
        {2'd1, 16'h0040, 4'd1},  // R2
        {2'd0, 16'h0040, 4'd0},  // R6
        {2'd2, 16'h0040, 4'd0},  // R4
        {2'd0, 16'h0040, 4'd1},  // R1
        {2'd2, 16'h0040, 4'd3}   // R4
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input bit is_ev, input bit coh, input logic [AW-1:0] a,
                          input bit exp_ok, input string tag);
        bit rdy;
        @(negedge clk);
        if (is_ev) begin ev_valid = 1; ev_coherent = coh; ev_addr = a; end
        else       begin wh_valid = 1; wh_coherent = coh; wh_addr = a; end
        #1;
        rdy = is_ev ? ev_ready : wh_ready;
        check(rdy == exp_ok, tag, rdy, exp_ok);
        @(negedge clk);
        ev_valid = 0; wh_valid = 0;
        if (exp_ok && coh)
            check(dir_msg_valid && dir_msg_evict == is_ev && dir_msg_addr == a, tag,
                  {dir_msg_valid, dir_msg_evict, dir_msg_addr}, {1'b1, is_ev, a});
        else
            check(!dir_msg_valid, tag, dir_msg_valid, 0);
    endtask

    task automatic do_ack(input logic [AW-1:0] a, input logic [3:0] exp, input string tag);
        @(negedge clk);
        ack_valid = 1; ack_addr = a;
        @(negedge clk);
        ack_valid = 0;
        if (exp[3])
            check(ack_orphan && !commit_valid, tag, {ack_orphan, commit_valid}, 2'b10);
        else
            check(commit_valid && !ack_orphan && commit_addr == a && commit_state == exp[1:0],
                  tag, {commit_valid, commit_state, commit_addr}, {1'b1, exp[1:0], a});
    endtask

    task automatic do_probe(input logic [AW-1:0] a, input bit exp, input string tag);
        @(negedge clk);
        probe_addr = a;
        #1;
        check(probe_locked == exp, tag, probe_locked, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; wh_valid = 0; wh_coherent = 0; wh_addr = '0;
        ev_valid = 0; ev_coherent = 0; ev_addr = '0;
        ack_valid = 0; ack_addr = '0; probe_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        wh_coherent = 1; ev_coherent = 1; #1;
        // R10 reset state
        check(wh_ready && ev_ready && !dir_msg_valid && !commit_valid && !ack_orphan && !probe_locked,
              "R10", {wh_ready, ev_ready, dir_msg_valid, commit_valid, ack_orphan, probe_locked}, 6'b110000);

        for (int i = 0; i < 14; i++) begin
            case (VEC[i][21:20])
                2'd0: do_req(0, 1, VEC[i][19:4], VEC[i][0], "R1/R6 vec");
                2'd1: do_req(1, 1, VEC[i][19:4], VEC[i][0], "R2/R3 vec");
                2'd2: do_ack(VEC[i][19:4], VEC[i][3:0], "R4/R7 vec");
                default: do_probe(VEC[i][19:4], VEC[i][0], "R3 vec");
            endcase
        end

        // R5: fill every slot, then refuse
        do_req(0, 1, 16'h0100, 1, "R5 fill");
        do_req(0, 1, 16'h0101, 1, "R5 fill");
        do_req(1, 1, 16'h0102, 1, "R5 fill");
        do_req(0, 1, 16'h0103, 1, "R5 fill");
        do_req(0, 1, 16'h0104, 0, "R5 full write");
        do_req(1, 1, 16'h0105, 0, "R5 full evict");
        // R8: non-coherent passes while full, no lock
        do_req(1, 0, 16'h0105, 1, "R8 evict");
        do_req(0, 0, 16'h0104, 1, "R8 write");
        do_probe(16'h0104, 0, "R8 no lock");
        do_ack(16'h0102, 4'd0, "R4 evict");

        // R9: both coherent ports in one cycle, one slot free
        @(negedge clk);
        ev_valid = 1; ev_coherent = 1; ev_addr = 16'h0200;
        wh_valid = 1; wh_coherent = 1; wh_addr = 16'h0201;
        #1;
        check(ev_ready && !wh_ready, "R9 ready", {ev_ready, wh_ready}, 2'b10);
        @(negedge clk);
        ev_valid = 0; wh_valid = 0;
        check(dir_msg_valid && dir_msg_evict && dir_msg_addr == 16'h0200, "R9 notice",
              {dir_msg_valid, dir_msg_evict, dir_msg_addr}, {2'b11, 16'h0200});
        do_probe(16'h0201, 0, "R9 write not locked");

        do_ack(16'h0100, 4'd3, "R4 drain");
        do_ack(16'h0101, 4'd3, "R4 drain");
        do_ack(16'h0103, 4'd3, "R4 drain");
        do_ack(16'h0200, 4'd0, "R4 drain");

        // R6: held write hit, ack arrives while it waits
        do_req(0, 1, 16'h0300, 1, "R6 lock");
        @(negedge clk);
        wh_valid = 1; wh_coherent = 1; wh_addr = 16'h0300;
        #1;
        check(!wh_ready, "R6 held", wh_ready, 0);
        @(negedge clk);
        ack_valid = 1; ack_addr = 16'h0300;
        #1;
        check(!wh_ready, "R6 same cycle", wh_ready, 0);
        @(negedge clk);
        ack_valid = 0;
        #1;
        check(commit_valid && commit_state == 2'd3, "R6 commit", {commit_valid, commit_state}, 3'b111);
        check(wh_ready, "R6 released", wh_ready, 1);
        @(negedge clk);
        wh_valid = 0;
        check(dir_msg_valid && !dir_msg_evict && dir_msg_addr == 16'h0300, "R6 relock",
              {dir_msg_valid, dir_msg_evict, dir_msg_addr}, {2'b10, 16'h0300});
        do_ack(16'h0300, 4'd3, "R6 final");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule